// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block tells an out-of-order core's scheduler whether a memory instruction should wait for an older store that is still in flight. It learns which loads and stores alias from memory-ordering violations and groups them into store sets. Two tables hold what it has learned. The set table is indexed by instruction address and gives a set identifier. The last-store table is indexed by that identifier and records the sequence number of the most recently fetched store in the set.

Front-end logic reports each fetched load or store on the insert port. It then asks the lookup port which store, if any, the instruction must wait behind. The scheduler reports store issue. Recovery logic reports squashes. The violation detector reports an offending store/load address pair. A small in-flight table remembers the set of each tracked store, so that issue and squash can retire its last-store entry. After a fixed number of accepted inserts, both tables are wiped so the predictor never saturates.

Top module: `mem_dep_predictor`

## Requirements
- R1: After reset every entry of both tables is invalid, `lookHit` is 0, `lookSeq` is 0 and `insReady` is 1.
- R2: The set-table index is `(pc >> OFFSET_BITS) & (SSIT_ENTRIES-1)`. The lookup is combinational. It returns the last-store sequence number with `lookHit`=1 only when both the set entry and the last-store entry for that set are valid. Otherwise it returns 0 with `lookHit`=0.
- R3: On a violation where neither address has a valid set entry, both entries get the identifier `(storePc ^ (storePc >> 10)) % LFST_ENTRIES` and become valid.
- R4: On a violation where exactly one address has a valid set entry, its identifier is copied to the other address's entry. When both are valid, both get the smaller of the two identifiers.
- R5: An accepted store insert whose set entry is valid writes its sequence number into that set's last-store entry, marks the entry valid and takes an in-flight slot. A store whose set entry is invalid changes no table.
- R6: An accepted load insert changes no table entry.
- R7: A store issue frees the store's in-flight slot. It invalidates the set's last-store entry only if that entry still holds the issued sequence number. An issue with `issueIsStore`=0 changes nothing.
- R8: A squash frees every tracked store whose sequence number is greater than `squashSeq`. Any last-store entry holding one of those numbers becomes invalid. Older stores and their entries are kept.
- R9: When all SLOTS in-flight slots are busy, a store insert whose set entry is valid is refused (`insReady`=0, no change). Loads and stores with an invalid set entry are still accepted.
- R10: Accepted inserts are counted. The insert that brings the count to CLEAR_PERIOD invalidates every entry of both tables at that same edge, and the count restarts from 0.
- R11: One operation is taken per cycle, with priority squash > violation > issue > insert. A lower-priority request is dropped that cycle. `insReady` is 0 whenever a squash, violation or issue is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| violValid | input | 1 | Ordering violation report |
| violStorePc | input | PC_W | Address of the offending store |
| violLoadPc | input | PC_W | Address of the offending load |
| insValid | input | 1 | Fetched memory instruction insert |
| insIsStore | input | 1 | 1 for a store, 0 for a load |
| insPc | input | PC_W | Address of the inserted instruction |
| insSeq | input | SEQ_W | Sequence number of the inserted instruction |
| insReady | output | 1 | Insert accepted this cycle |
| issueValid | input | 1 | Issue notification |
| issueIsStore | input | 1 | Issued instruction is a store |
| issueSeq | input | SEQ_W | Sequence number of the issued instruction |
| squashValid | input | 1 | Squash request |
| squashSeq | input | SEQ_W | Youngest surviving sequence number |
| lookPc | input | PC_W | Lookup address |
| lookSeq | output | SEQ_W | Store to wait for, 0 if none |
| lookHit | output | 1 | A dependence was found |

## Verification
The bench sweeps every set-table index after each step and compares each one against an arithmetic model. A wrong index mask or a hash taken from the load address would return the wrong store at some index. The violation cases include neither, one and both entries valid. A merge that kept the larger identifier, or that overwrote an already valid entry, would leave two indices pointing at different sets. Issuing an older store of a set whose entry has already moved on must leave that entry alone. A squash must drop only stores younger than the boundary. A design that compared the wrong way, or cleared on any slot match, would lose a live dependence. The bench fills the in-flight slots to check the refusal, and counts inserts exactly to the clearing one, where an off-by-one counter would wipe a cycle early or late.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  // One-cycle strobes from the control to the datapath.
  typedef struct packed {
    logic squash;
    logic viol;
    logic issue;
    logic insLoad;
    logic insStore;
    logic clear;
  } mdp_strobe_t;
endpackage

// File: rtl/mdp_ctrl.sv
module mdp_ctrl
  import mdp_pkg::*;
#(
  parameter int CLEAR_PERIOD = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        squashValid,
  input  logic        violValid,
  input  logic        issueValid,
  input  logic        issueIsStore,
  input  logic        insValid,
  input  logic        insIsStore,
  input  logic        insLinked,
  input  logic        slotsFull,
  output logic        insReady,
  output mdp_strobe_t strb
);
  localparam int CNT_W = (CLEAR_PERIOD > 1) ? $clog2(CLEAR_PERIOD) : 1;

  logic [CNT_W-1:0] opCount;
  logic             insBlocked;
  logic             insStall;
  logic             insAcc;
  logic             lastOp;

  assign insBlocked = squashValid | violValid | issueValid;
  assign insStall   = insIsStore & insLinked & slotsFull;
  assign insReady   = ~insBlocked & ~insStall;
  assign insAcc     = insValid & insReady;
  assign lastOp     = (opCount == CNT_W'(CLEAR_PERIOD - 1));

  always_comb begin
    strb          = '0;
    strb.squash   = squashValid;
    strb.viol     = violValid & ~squashValid;
    strb.issue    = issueValid & issueIsStore & ~squashValid & ~violValid;
    strb.insLoad  = insAcc & ~insIsStore;
    strb.insStore = insAcc & insIsStore;
    strb.clear    = insAcc & lastOp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opCount <= '0;
    end else if (insAcc) begin
      if (lastOp) opCount <= '0;
      else        opCount <= opCount + 1'b1;
    end
  end
endmodule

// File: rtl/mdp_datapath.sv
module mdp_datapath
  import mdp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int SEQ_W        = 16,
  parameter int OFFSET_BITS  = 2,
  parameter int SSIT_ENTRIES = 16,
  parameter int LFST_ENTRIES = 8,
  parameter int SLOTS        = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdp_strobe_t      strb,
  input  logic [PC_W-1:0]  violStorePc,
  input  logic [PC_W-1:0]  violLoadPc,
  input  logic [PC_W-1:0]  insPc,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic [SEQ_W-1:0] issueSeq,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [PC_W-1:0]  lookPc,
  output logic [SEQ_W-1:0] lookSeq,
  output logic             lookHit,
  output logic             insLinked,
  output logic             slotsFull
);
  localparam int IDX_W  = (SSIT_ENTRIES > 1) ? $clog2(SSIT_ENTRIES) : 1;
  localparam int SET_W  = (LFST_ENTRIES > 1) ? $clog2(LFST_ENTRIES) : 1;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // Set table
  logic [SET_W-1:0]        ssitId [SSIT_ENTRIES];
  logic [SSIT_ENTRIES-1:0] ssitVld;
  // Last-store table
  logic [SEQ_W-1:0]        lfstSeq [LFST_ENTRIES];
  logic [LFST_ENTRIES-1:0] lfstVld;
  // In-flight store slots
  logic [SEQ_W-1:0]        slotSeq [SLOTS];
  logic [SET_W-1:0]        slotSet [SLOTS];
  logic [SLOTS-1:0]        slotVld;

  function automatic logic [IDX_W-1:0] idxOf(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] sh;
    sh = pc >> OFFSET_BITS;
    return sh[IDX_W-1:0];
  endfunction

  function automatic logic [SET_W-1:0] hashSet(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] h;
    h = (pc ^ (pc >> 10)) % PC_W'(LFST_ENTRIES);
    return h[SET_W-1:0];
  endfunction

  // Lookup
  logic [IDX_W-1:0] lookIdx;
  logic [SET_W-1:0] lookSet;
  assign lookIdx = idxOf(lookPc);
  assign lookSet = ssitId[lookIdx];
  assign lookHit = ssitVld[lookIdx] & lfstVld[lookSet];
  assign lookSeq = lookHit ? lfstSeq[lookSet] : '0;

  // Insert
  logic [IDX_W-1:0] insIdx;
  logic [SET_W-1:0] insSet;
  assign insIdx    = idxOf(insPc);
  assign insSet    = ssitId[insIdx];
  assign insLinked = ssitVld[insIdx];
  assign slotsFull = &slotVld;

  logic [SLOT_W-1:0] freeSlot;
  always_comb begin
    freeSlot = '0;
    for (int k = SLOTS - 1; k >= 0; k--)
      if (!slotVld[k]) freeSlot = SLOT_W'(k);
  end

  // Violation merge
  logic [IDX_W-1:0] sIdx, lIdx;
  logic [SET_W-1:0] sId, lId, violId;
  logic             sV, lV;
  assign sIdx = idxOf(violStorePc);
  assign lIdx = idxOf(violLoadPc);
  assign sId  = ssitId[sIdx];
  assign lId  = ssitId[lIdx];
  assign sV   = ssitVld[sIdx];
  assign lV   = ssitVld[lIdx];

  always_comb begin
    unique case ({sV, lV})
      2'b00:   violId = hashSet(violStorePc);
      2'b10:   violId = sId;
      2'b01:   violId = lId;
      default: violId = (sId < lId) ? sId : lId;
    endcase
  end

  // Issue
  logic              issHit;
  logic [SLOT_W-1:0] issSlot;
  logic [SET_W-1:0]  issSet;
  logic              issKill;
  always_comb begin
    issHit  = 1'b0;
    issSlot = '0;
    for (int k = SLOTS - 1; k >= 0; k--)
      if (slotVld[k] && slotSeq[k] == issueSeq) begin
        issHit  = 1'b1;
        issSlot = SLOT_W'(k);
      end
  end
  assign issSet  = slotSet[issSlot];
  assign issKill = issHit & (lfstSeq[issSet] == issueSeq);

  // Squash
  logic [SLOTS-1:0]        sqKill;
  logic [LFST_ENTRIES-1:0] lfstKill;
  generate
    for (genvar k = 0; k < SLOTS; k++) begin : g_sq
      assign sqKill[k] = slotVld[k] & (slotSeq[k] > squashSeq);
    end
  endgenerate

  always_comb begin
    lfstKill = '0;
    for (int j = 0; j < LFST_ENTRIES; j++)
      for (int k = 0; k < SLOTS; k++)
        if (sqKill[k] && slotSet[k] == SET_W'(j) && lfstSeq[j] == slotSeq[k])
          lfstKill[j] = 1'b1;
  end

  // State update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssitVld <= '0;
      lfstVld <= '0;
      slotVld <= '0;
      for (int i = 0; i < SSIT_ENTRIES; i++) ssitId[i] <= '0;
      for (int j = 0; j < LFST_ENTRIES; j++) lfstSeq[j] <= '0;
      for (int k = 0; k < SLOTS; k++) begin
        slotSeq[k] <= '0;
        slotSet[k] <= '0;
      end
    end else begin
      if (strb.viol) begin
        ssitId[sIdx]  <= violId;
        ssitId[lIdx]  <= violId;
        ssitVld[sIdx] <= 1'b1;
        ssitVld[lIdx] <= 1'b1;
      end
      if (strb.insStore && insLinked) begin
        lfstSeq[insSet]   <= insSeq;
        lfstVld[insSet]   <= 1'b1;
        slotSeq[freeSlot] <= insSeq;
        slotSet[freeSlot] <= insSet;
        slotVld[freeSlot] <= 1'b1;
      end
      if (strb.issue && issHit) begin
        slotVld[issSlot] <= 1'b0;
        if (issKill) lfstVld[issSet] <= 1'b0;
      end
      if (strb.squash) begin
        slotVld <= slotVld & ~sqKill;
        lfstVld <= lfstVld & ~lfstKill;
      end
      if (strb.clear) begin
        ssitVld <= '0;
        lfstVld <= '0;
      end
    end
  end
endmodule

// File: rtl/mem_dep_predictor.sv
module mem_dep_predictor
  import mdp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int SEQ_W        = 16,
  parameter int OFFSET_BITS  = 2,
  parameter int SSIT_ENTRIES = 16,
  parameter int LFST_ENTRIES = 8,
  parameter int SLOTS        = 4,
  parameter int CLEAR_PERIOD = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             violValid,
  input  logic [PC_W-1:0]  violStorePc,
  input  logic [PC_W-1:0]  violLoadPc,
  input  logic             insValid,
  input  logic             insIsStore,
  input  logic [PC_W-1:0]  insPc,
  input  logic [SEQ_W-1:0] insSeq,
  output logic             insReady,
  input  logic             issueValid,
  input  logic             issueIsStore,
  input  logic [SEQ_W-1:0] issueSeq,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [PC_W-1:0]  lookPc,
  output logic [SEQ_W-1:0] lookSeq,
  output logic             lookHit
);
  mdp_strobe_t strb;
  logic        insLinked;
  logic        slotsFull;

  mdp_ctrl #(.CLEAR_PERIOD(CLEAR_PERIOD)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .squashValid(squashValid), .violValid(violValid),
    .issueValid(issueValid), .issueIsStore(issueIsStore),
    .insValid(insValid), .insIsStore(insIsStore),
    .insLinked(insLinked), .slotsFull(slotsFull),
    .insReady(insReady), .strb(strb)
  );

  mdp_datapath #(
    .PC_W(PC_W), .SEQ_W(SEQ_W), .OFFSET_BITS(OFFSET_BITS),
    .SSIT_ENTRIES(SSIT_ENTRIES), .LFST_ENTRIES(LFST_ENTRIES), .SLOTS(SLOTS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .violStorePc(violStorePc), .violLoadPc(violLoadPc),
    .insPc(insPc), .insSeq(insSeq),
    .issueSeq(issueSeq), .squashSeq(squashSeq),
    .lookPc(lookPc), .lookSeq(lookSeq), .lookHit(lookHit),
    .insLinked(insLinked), .slotsFull(slotsFull)
  );
endmodule

// File: rtl/mdp_checker.sv
module mdp_checker
  import mdp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input mdp_strobe_t      strb,
  input logic             squashValid,
  input logic             insIsStore,
  input logic             insLinked,
  input logic             slotsFull,
  input logic             insReady,
  input logic [PC_W-1:0]  insPc,
  input logic [SEQ_W-1:0] insSeq,
  input logic [PC_W-1:0]  lookPc,
  input logic [SEQ_W-1:0] lookSeq,
  input logic             lookHit
);
  assert_squash_first_R11: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |-> (!insReady && !strb.viol && !strb.issue));

  assert_one_op_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.squash, strb.viol, strb.issue, strb.insLoad, strb.insStore}));

  assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (insIsStore && insLinked && slotsFull) |-> !insReady);

  assert_wipe_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !lookHit);

  assert_store_visible_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.insStore && insLinked && !strb.clear) |=>
      ((lookPc != $past(insPc)) || (lookHit && lookSeq == $past(insSeq))));

  assert_load_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.insLoad && !strb.clear) |=>
      ((lookPc != $past(lookPc)) || (lookSeq == $past(lookSeq))));
endmodule

bind mem_dep_predictor mdp_checker #(.PC_W(PC_W), .SEQ_W(SEQ_W)) chk_i (
  .clk(clk), .rstN(rstN), .strb(strb), .squashValid(squashValid),
  .insIsStore(insIsStore), .insLinked(insLinked), .slotsFull(slotsFull),
  .insReady(insReady), .insPc(insPc), .insSeq(insSeq),
  .lookPc(lookPc), .lookSeq(lookSeq), .lookHit(lookHit)
);

// File: tb/mem_dep_predictor_tb_top.sv
module mem_dep_predictor_tb_top;
  localparam int PC_W = 32, SEQ_W = 16, OFF = 2, NI = 16, NS = 8, NSLOT = 4, PERIOD = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic violValid = 0, insValid = 0, insIsStore = 0, issueValid = 0, issueIsStore = 0, squashValid = 0;
  logic [PC_W-1:0] violStorePc = 0, violLoadPc = 0, insPc = 0, lookPc = 0;
  logic [SEQ_W-1:0] insSeq = 0, issueSeq = 0, squashSeq = 0;
  logic insReady, lookHit;
  logic [SEQ_W-1:0] lookSeq;

  always #5 clk = ~clk;

  mem_dep_predictor #(.PC_W(PC_W), .SEQ_W(SEQ_W), .OFFSET_BITS(OFF), .SSIT_ENTRIES(NI),
    .LFST_ENTRIES(NS), .SLOTS(NSLOT), .CLEAR_PERIOD(PERIOD)) dut_i (.*);

  int checks = 0, fails = 0;

  // Reference model built from the requirements
  int mId[NI]; bit mIdV[NI];
  int mLf[NS]; bit mLfV[NS];
  int mSlSeq[NSLOT], mSlSet[NSLOT]; bit mSlV[NSLOT];
  int mCnt = 0;

  function automatic int idxOf(int pc); return (pc >> OFF) & (NI - 1); endfunction
  function automatic int hashOf(int pc); return (pc ^ (pc >> 10)) % NS; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < NI; i++) begin
      int e;
      lookPc = (i << OFF) | (i << 12);
      #1;
      e = (mIdV[i] && mLfV[mId[i]]) ? mLf[mId[i]] : 0;
      chk(req, lookSeq, e);
      chk(req, lookHit, (mIdV[i] && mLfV[mId[i]]) ? 1 : 0);
    end
  endtask

  function automatic bit fullM();
    for (int k = 0; k < NSLOT; k++) if (!mSlV[k]) return 0;
    return 1;
  endfunction

  task automatic modelViol(int sp, int lp);
    int si = idxOf(sp), li = idxOf(lp), id;
    if (!mIdV[si] && !mIdV[li]) id = hashOf(sp);
    else if (!mIdV[li]) id = mId[si];
    else if (!mIdV[si]) id = mId[li];
    else id = (mId[si] < mId[li]) ? mId[si] : mId[li];
    mId[si] = id; mId[li] = id; mIdV[si] = 1; mIdV[li] = 1;
  endtask

  task automatic modelSquash(int s);
    for (int k = 0; k < NSLOT; k++)
      if (mSlV[k] && mSlSeq[k] > s) begin
        if (mLf[mSlSet[k]] == mSlSeq[k]) mLfV[mSlSet[k]] = 0;
        mSlV[k] = 0;
      end
  endtask

  task automatic opViol(int sp, int lp);
    @(negedge clk);
    violValid = 1; violStorePc = sp; violLoadPc = lp;
    @(posedge clk); modelViol(sp, lp);
    #1 violValid = 0;
  endtask

  task automatic opIns(bit st, int pc, int seq);
    bit expR;
    int ix = idxOf(pc);
    @(negedge clk);
    insValid = 1; insIsStore = st; insPc = pc; insSeq = SEQ_W'(seq);
    #1;
    expR = !(st && mIdV[ix] && fullM());
    chk("R9", insReady, expR);
    @(posedge clk);
    if (expR) begin
      if (st && mIdV[ix]) begin
        mLf[mId[ix]] = seq; mLfV[mId[ix]] = 1;
        for (int k = 0; k < NSLOT; k++)
          if (!mSlV[k]) begin mSlV[k] = 1; mSlSeq[k] = seq; mSlSet[k] = mId[ix]; break; end
      end
      mCnt++;
      if (mCnt == PERIOD) begin
        mCnt = 0;
        for (int i = 0; i < NI; i++) mIdV[i] = 0;
        for (int j = 0; j < NS; j++) mLfV[j] = 0;
      end
    end
    #1 insValid = 0;
  endtask

  task automatic opIssue(bit st, int seq);
    @(negedge clk);
    issueValid = 1; issueIsStore = st; issueSeq = SEQ_W'(seq);
    @(posedge clk);
    if (st)
      for (int k = 0; k < NSLOT; k++)
        if (mSlV[k] && mSlSeq[k] == seq) begin
          if (mLf[mSlSet[k]] == seq) mLfV[mSlSet[k]] = 0;
          mSlV[k] = 0; break;
        end
    #1 issueValid = 0;
  endtask

  task automatic opSquash(int s);
    @(negedge clk);
    squashValid = 1; squashSeq = SEQ_W'(s);
    @(posedge clk); modelSquash(s);
    #1 squashValid = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    #1 chk("R1", insReady, 1);
    sweep("R1");
    // R3: fresh set from store hash (store idx 1, load idx 4, id 5)
    opViol(32'h404, 32'h10);
    sweep("R3");
    opIns(1, 32'h404, 100);
    sweep("R5");
    // R4: only the load valid, store idx 8 takes its id
    opViol(32'h820, 32'h10);
    sweep("R4");
    // R3 then R4 merge of two valid sets (5 and 3)
    opViol(32'h3C0C, 32'h18);
    sweep("R3");
    opViol(32'h404, 32'h18);
    sweep("R4");
    // R5 and R9: fill the in-flight slots
    opIns(1, 32'h404, 110);
    opIns(1, 32'h820, 120);
    opIns(1, 32'h3C0C, 130);
    sweep("R5");
    opIns(1, 32'h404, 140);    // refused
    sweep("R9");
    opIns(1, 32'h3C, 141);     // unlinked store, accepted
    opIns(0, 32'h404, 142);    // load, accepted
    sweep("R6");
    // R7: older store leaves entry, load issue ignored, youngest clears it
    opIssue(1, 110);
    sweep("R7");
    opIssue(0, 130);
    sweep("R7");
    opIssue(1, 130);
    sweep("R7");
    opIssue(1, 120);
    sweep("R7");
    // R8: squash keeps older store, drops younger
    opIns(1, 32'h404, 200);
    opIns(1, 32'h10, 210);
    sweep("R8");
    opSquash(205);
    sweep("R8");
    // R11: squash with insert; violation with issue
    @(negedge clk);
    squashValid = 1; squashSeq = 0; insValid = 1; insIsStore = 1; insPc = 32'h3C0C; insSeq = 300;
    #1 chk("R11", insReady, 0);
    @(posedge clk); modelSquash(0);
    #1 squashValid = 0; insValid = 0;
    sweep("R11");
    opIns(1, 32'h820, 310);
    @(negedge clk);
    violValid = 1; violStorePc = 32'h40; violLoadPc = 32'h44;
    issueValid = 1; issueIsStore = 1; issueSeq = 310;
    #1 chk("R11", insReady, 0);
    @(posedge clk); modelViol(32'h40, 32'h44);
    #1 violValid = 0; issueValid = 0;
    sweep("R11");
    // R10: loads up to the clearing insert
    while (mCnt != PERIOD - 1) begin
      opIns(0, 32'h80, 0);
      sweep("R10");
    end
    opIns(1, 32'h820, 400);
    sweep("R10");
    // R2: relearn across all store indices after the wipe
    for (int i = 0; i < NI; i++) begin
      opViol((i << OFF) | (i << 10), ((i + 5) % NI) << OFF);
      opIns(1, (i << OFF) | (i << 10), 500 + i);
      sweep("R2");
      opSquash(0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule